// File: doc/BRIEF.md
# Converter Linearity Monitor

This block measures how far a converter's transfer curve strays from an even staircase. A slow, non-decreasing ramp is applied to the converter under test. Each cycle the monitor can receive one sample: the ramp level at that moment, in units of 1/64 LSB, and the code the converter returned. The code must already be corrected for offset and gain, because the non-linearity figures are only meaningful once those errors are removed.

The monitor notes the ramp level at which the code first rises above its previous value. From two such edges in a row it gets the width of the code between them. It keeps the largest and smallest differential non-linearity, which is the width minus one LSB. It also keeps the largest and smallest integral non-linearity, which is the vertical gap between the measured curve and a perfect staircase, taken at the centre of each step. All four figures are signed values with 6 fractional bits.

A done flag rises once the top code has been reached. A clear input restarts the measurement.

Top module: `adc_lin_monitor`

## Requirements
- R1: After reset or a clear pulse, both maxima read the most negative value -2^(OUT_W-1), both minima read the most positive value 2^(OUT_W-1)-1, and done is 0.
- R2: An edge is recorded at the ramp level of the first accepted sample whose code is higher than the last accepted code. Samples with smp_valid low, and samples whose code is equal to or lower than the last accepted code, leave all results unchanged.
- R3: For each code c that has both an entry edge and an exit edge, DNL = (exit − entry) − 64, in 1/64 LSB. The running maximum and minimum of these values are reported on dnl_max and dnl_min.
- R4: The code carried by the first sample after a clear has no entry edge. The last code reached has no exit edge. Neither code contributes to DNL or INL.
- R5: When the code rises by more than one between accepted samples, each code that was skipped counts as a step of zero width. Each skipped code contributes a DNL of −64. Skipped codes are left out of INL.
- R6: For each code c that has both edges, INL = 64·c − floor((entry + exit)/2). The running maximum and minimum are reported on inl_max and inl_min.
- R7: done goes to 1 one clock after a sample with the all-ones code is accepted. It stays at 1 until reset or clear. While done is 1, incoming samples are ignored and all four results hold their values.
- R8: A converter whose edge into code c sits at 64·c − 32 gives 0 on all four results.
- R9: Results only widen between clears. A maximum never decreases and a minimum never increases. dnl_min never falls below −64 for a non-decreasing ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Restarts the measurement |
| smp_valid | input | 1 | A sample is present this cycle |
| smp_code | input | CODE_W | Corrected converter code, unsigned |
| ramp_pos | input | CODE_W+FRAC_W | Ramp level, 1/64 LSB per unit |
| dnl_max | output | CODE_W+FRAC_W+2 | Largest DNL, signed, 6 fractional bits |
| dnl_min | output | CODE_W+FRAC_W+2 | Smallest DNL, signed, 6 fractional bits |
| inl_max | output | CODE_W+FRAC_W+2 | Largest INL, signed, 6 fractional bits |
| inl_min | output | CODE_W+FRAC_W+2 | Smallest INL, signed, 6 fractional bits |
| done | output | 1 | Top code has been reached |

## Verification
A 4-bit converter is swept across its full 1024-position ramp several times, each sweep with a different edge table. A perfect staircase confirms the zero baseline. A jittered staircase, mixed with dropped valid cycles and single-sample drops in the code, tells genuine edges apart from noise and invalid samples. A table with a missing code tests the zero-width rule. A shifted table with a non-zero first code, and a stretched table that never reaches the top code, check which codes are excluded and when done rises. Samples sent after done confirm that the results are frozen.

// File: rtl/adc_lin_pkg.sv
package adc_lin_pkg;

    // fine ramp resolution: 2**LIN_FRAC_W positions per LSB
    localparam int LIN_FRAC_W = 6;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,   // nothing accepted since clear
        TRK_OPEN  = 2'd1,   // first code held, no entry edge yet
        TRK_TRACK = 2'd2,   // current code has an entry edge
        TRK_DONE  = 2'd3    // top code reached, inputs ignored
    } trk_state_e;

    typedef struct packed {
        logic step;   // a bounded step closed
        logic gap;    // one or more codes were skipped
    } trk_flags_t;

endpackage

// File: rtl/lin_edge_tracker.sv
module lin_edge_tracker
    import adc_lin_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int FRAC_W = LIN_FRAC_W
) (
    input  logic                              clk,
    input  logic                              wipe,
    input  logic                              smp_valid,
    input  logic [CODE_W-1:0]                 smp_code,
    input  logic [CODE_W+FRAC_W-1:0]          ramp_pos,
    output trk_flags_t                        ev_flags,
    output logic signed [CODE_W+FRAC_W+1:0]   ev_dnl,
    output logic signed [CODE_W+FRAC_W+1:0]   ev_inl,
    output logic                              done
);
    localparam int POS_W = CODE_W + FRAC_W;
    localparam int OUT_W = POS_W + 2;
    localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
    localparam logic signed [OUT_W-1:0] ONE_S = OUT_W'(2 ** FRAC_W);

    trk_state_e          st;
    logic [CODE_W-1:0]   prev_code;
    logic [POS_W-1:0]    t_in;

    logic                     rises, skips;
    logic [POS_W:0]           width_w, sum_w;
    logic [POS_W-1:0]         mid_w, ideal_w;
    logic signed [OUT_W-1:0]  dnl_c, inl_c;

    always_comb begin
        rises   = smp_code > prev_code;
        skips   = {1'b0, smp_code} > ({1'b0, prev_code} + (CODE_W+1)'(1));
        width_w = {1'b0, ramp_pos} - {1'b0, t_in};
        sum_w   = {1'b0, ramp_pos} + {1'b0, t_in};
        mid_w   = sum_w[POS_W:1];
        ideal_w = {prev_code, {FRAC_W{1'b0}}};
        dnl_c   = $signed({1'b0, width_w}) - ONE_S;
        inl_c   = $signed({2'b00, ideal_w}) - $signed({2'b00, mid_w});
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            st        <= TRK_IDLE;
            prev_code <= '0;
            t_in      <= '0;
            ev_flags  <= '0;
            ev_dnl    <= '0;
            ev_inl    <= '0;
        end else begin
            ev_flags <= '0;
            if (smp_valid && st != TRK_DONE) begin
                if (st == TRK_IDLE) begin
                    prev_code <= smp_code;
                    st        <= (smp_code == CODE_TOP) ? TRK_DONE : TRK_OPEN;
                end else if (rises) begin
                    ev_flags.step <= (st == TRK_TRACK);
                    ev_flags.gap  <= skips;
                    ev_dnl        <= dnl_c;
                    ev_inl        <= inl_c;
                    t_in          <= ramp_pos;
                    prev_code     <= smp_code;
                    st            <= (smp_code == CODE_TOP) ? TRK_DONE : TRK_TRACK;
                end
            end
        end
    end

    assign done = (st == TRK_DONE);

endmodule

// File: rtl/lin_extreme.sv
module lin_extreme #(
    parameter int W = 18
) (
    input  logic                clk,
    input  logic                wipe,
    input  logic                a_en,
    input  logic signed [W-1:0] a_val,
    input  logic                b_en,
    input  logic signed [W-1:0] b_val,
    output logic signed [W-1:0] mx,
    output logic signed [W-1:0] mn
);
    localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic signed [W-1:0] nx_mx, nx_mn;

    always_comb begin
        nx_mx = mx;
        nx_mn = mn;
        if (a_en && a_val > nx_mx) nx_mx = a_val;
        if (b_en && b_val > nx_mx) nx_mx = b_val;
        if (a_en && a_val < nx_mn) nx_mn = a_val;
        if (b_en && b_val < nx_mn) nx_mn = b_val;
    end

    always_ff @(posedge clk) begin
        if (wipe) begin
            mx <= MOST_NEG;
            mn <= MOST_POS;
        end else begin
            mx <= nx_mx;
            mn <= nx_mn;
        end
    end

endmodule

// File: rtl/adc_lin_monitor.sv
module adc_lin_monitor
    import adc_lin_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int FRAC_W = LIN_FRAC_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              clr,
    input  logic                              smp_valid,
    input  logic [CODE_W-1:0]                 smp_code,
    input  logic [CODE_W+FRAC_W-1:0]          ramp_pos,
    output logic signed [CODE_W+FRAC_W+1:0]   dnl_max,
    output logic signed [CODE_W+FRAC_W+1:0]   dnl_min,
    output logic signed [CODE_W+FRAC_W+1:0]   inl_max,
    output logic signed [CODE_W+FRAC_W+1:0]   inl_min,
    output logic                              done
);
    localparam int OUT_W = CODE_W + FRAC_W + 2;
    localparam logic signed [OUT_W-1:0] ZERO_W_DNL = -OUT_W'(2 ** FRAC_W);

    logic                     wipe;
    trk_flags_t               ev_flags;
    logic signed [OUT_W-1:0]  ev_dnl, ev_inl;

    assign wipe = rst | clr;

    lin_edge_tracker #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_trk (
        .clk       (clk),
        .wipe      (wipe),
        .smp_valid (smp_valid),
        .smp_code  (smp_code),
        .ramp_pos  (ramp_pos),
        .ev_flags  (ev_flags),
        .ev_dnl    (ev_dnl),
        .ev_inl    (ev_inl),
        .done      (done)
    );

    // skipped codes feed the DNL tracker as zero-width steps
    lin_extreme #(.W(OUT_W)) u_dnl (
        .clk   (clk),
        .wipe  (wipe),
        .a_en  (ev_flags.step),
        .a_val (ev_dnl),
        .b_en  (ev_flags.gap),
        .b_val (ZERO_W_DNL),
        .mx    (dnl_max),
        .mn    (dnl_min)
    );

    lin_extreme #(.W(OUT_W)) u_inl (
        .clk   (clk),
        .wipe  (wipe),
        .a_en  (ev_flags.step),
        .a_val (ev_inl),
        .b_en  (1'b0),
        .b_val ('0),
        .mx    (inl_max),
        .mn    (inl_min)
    );

endmodule

// File: rtl/adc_lin_monitor_chk.sv
module adc_lin_monitor_chk #(
    parameter int CODE_W = 10,
    parameter int FRAC_W = 6
) (
    input logic                              clk,
    input logic                              rst,
    input logic                              clr,
    input logic signed [CODE_W+FRAC_W+1:0]   dnl_max,
    input logic signed [CODE_W+FRAC_W+1:0]   dnl_min,
    input logic signed [CODE_W+FRAC_W+1:0]   inl_max,
    input logic signed [CODE_W+FRAC_W+1:0]   inl_min,
    input logic                              done
);
    localparam int W = CODE_W + FRAC_W + 2;
    localparam logic signed [W-1:0] NEG_V = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] POS_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] FLOOR_V = -W'(2 ** FRAC_W);

    p_wipe_state_r1: assert property (@(posedge clk)
        (rst || clr) |=> (dnl_max == NEG_V && dnl_min == POS_V &&
                          inl_max == NEG_V && inl_min == POS_V && !done));

    p_dnl_max_grow_r9: assert property (@(posedge clk) disable iff (rst)
        !clr |=> $signed(dnl_max) >= $signed($past(dnl_max)));

    p_inl_min_shrink_r9: assert property (@(posedge clk) disable iff (rst)
        !clr |=> $signed(inl_min) <= $signed($past(inl_min)));

    p_dnl_floor_r5: assert property (@(posedge clk) disable iff (rst)
        $signed(dnl_min) >= $signed(FLOOR_V));

    p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);

    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (done && $past(done) && !clr) |=>
            ($stable(dnl_max) && $stable(dnl_min) &&
             $stable(inl_max) && $stable(inl_min)));

endmodule

bind adc_lin_monitor adc_lin_monitor_chk #(.CODE_W(CODE_W), .FRAC_W(FRAC_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .dnl_max (dnl_max),
    .dnl_min (dnl_min),
    .inl_max (inl_max),
    .inl_min (inl_min),
    .done    (done)
);

// File: tb/tb_adc_lin_monitor.sv
`timescale 1ns/100ps
module tb_adc_lin_monitor;
    localparam int CW    = 4;
    localparam int FW    = 6;
    localparam int PW    = CW + FW;
    localparam int OW    = PW + 2;
    localparam int TOPC  = (1 << CW) - 1;
    localparam int LASTP = (1 << PW) - 1;
    localparam int NEGV  = -(1 << (OW - 1));
    localparam int POSV  = (1 << (OW - 1)) - 1;

    logic clk = 0;
    logic rst = 1;
    logic clr = 0;
    logic smp_valid = 0;
    logic [CW-1:0] smp_code = '0;
    logic [PW-1:0] ramp_pos = '0;
    logic signed [OW-1:0] dnl_max, dnl_min, inl_max, inl_min;
    logic done;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 0;
    int thr [0:TOPC+1];
    int e_dmax, e_dmin, e_imax, e_imin, e_done;

    always #2.5 clk = ~clk;

    adc_lin_monitor #(.CODE_W(CW), .FRAC_W(FW)) dut (
        .clk(clk), .rst(rst), .clr(clr), .smp_valid(smp_valid),
        .smp_code(smp_code), .ramp_pos(ramp_pos),
        .dnl_max(dnl_max), .dnl_min(dnl_min),
        .inl_max(inl_max), .inl_min(inl_min), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int adc_code(input int p);
        int n = 0;
        for (int c = 1; c <= TOPC; c++) if (thr[c] <= p) n++;
        return n;
    endfunction

    // expected values straight from the edge table (R3 R4 R5 R6)
    task automatic compute_expected();
        int c0 = adc_code(0);
        e_dmax = NEGV; e_dmin = POSV; e_imax = NEGV; e_imin = POSV;
        for (int c = 1; c < TOPC; c++) begin
            if (c > c0 && thr[c+1] <= LASTP) begin
                int w = thr[c+1] - thr[c];
                int d = w - 64;
                if (d > e_dmax) e_dmax = d;
                if (d < e_dmin) e_dmin = d;
                if (w != 0) begin
                    int s = thr[c] + thr[c+1];
                    int i = 64 * c - ((s >= 0) ? s / 2 : -((-s + 1) / 2));
                    if (i > e_imax) e_imax = i;
                    if (i < e_imin) e_imin = i;
                end
            end
        end
        e_done = (thr[TOPC] <= LASTP) ? 1 : 0;
    endtask

    task automatic wipe_pulse();
        @(negedge clk); clr = 1;
        @(negedge clk); clr = 0;
    endtask

    task automatic run_sweep(input bit noisy);
        for (int p = 0; p <= LASTP; p++) begin
            int c = adc_code(p);
            if (noisy && p % 50 == 0) begin
                @(negedge clk); smp_valid = 0; smp_code = CW'(TOPC); ramp_pos = '0;
            end
            if (noisy && p > 0 && p % 97 == 0 && c > 0 &&
                adc_code(p - 1) == c && adc_code(p + 1) == c)
                c = c - 1;   // R2: lower code must be ignored
            @(negedge clk); smp_valid = 1; smp_code = CW'(c); ramp_pos = PW'(p);
        end
        @(negedge clk); smp_valid = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        check({tag, " dnl_max"}, int'(dnl_max), e_dmax);
        check({tag, " dnl_min"}, int'(dnl_min), e_dmin);
        check({tag, " inl_max"}, int'(inl_max), e_imax);
        check({tag, " inl_min"}, int'(inl_min), e_imin);
        check({tag, " done"}, int'(done), e_done);
    endtask

    task automatic check_init(input string tag);
        check({tag, " dnl_max"}, int'(dnl_max), NEGV);
        check({tag, " dnl_min"}, int'(dnl_min), POSV);
        check({tag, " inl_max"}, int'(inl_max), NEGV);
        check({tag, " inl_min"}, int'(inl_min), POSV);
        check({tag, " done"}, int'(done), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_init("R1 reset");

        // perfect staircase: R8
        for (int c = 0; c <= TOPC + 1; c++) thr[c] = 64 * c - 32;
        compute_expected();
        run_sweep(0);
        check_all("R8 R3 R6 perfect");

        // samples after done are ignored: R7
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); smp_valid = 1; smp_code = CW'(k % 3);
            ramp_pos = PW'(k * 37);
        end
        @(negedge clk); smp_valid = 0;
        repeat (3) @(negedge clk);
        check_all("R7 after done");

        wipe_pulse();
        @(negedge clk);
        check_init("R1 clear");

        // jittered edges with noise and invalid cycles: R2 R3 R6
        for (int c = 0; c <= TOPC + 1; c++) thr[c] = 64 * c - 32 + ((c * 37) % 41) - 20;
        compute_expected();
        run_sweep(1);
        check_all("R2 R3 R6 jitter");

        // one missing code and one double-width code: R5
        wipe_pulse();
        for (int c = 0; c <= TOPC + 1; c++) thr[c] = 64 * c - 32;
        thr[6] = thr[5];
        compute_expected();
        run_sweep(0);
        check_all("R5 missing");

        // shifted curve, first code is 1: R4
        wipe_pulse();
        for (int c = 0; c <= TOPC + 1; c++) thr[c] = 64 * c - 112;
        compute_expected();
        run_sweep(0);
        check_all("R4 offset");

        // stretched curve, top code never reached: R4 R7
        wipe_pulse();
        for (int c = 0; c <= TOPC + 1; c++) thr[c] = 72 * c;
        compute_expected();
        run_sweep(1);
        check_all("R4 R7 stretched");

        fin = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule